// File: doc/BRIEF.md
# Four-Channel DMA Programming Register Block

This block is the register side of a four-channel DMA controller. A host programs each channel's 16-bit start address and 16-bit transfer length one byte at a time. One byte-select state machine, shared by every channel, decides whether each channel-port access reaches the low byte or the high byte. A separate transfer engine, which sits outside this block, reports each channel's live position through a write-back port. The host can read that position back at any time as the current address and the remaining length.

Sixteen port offsets are decoded. Offsets 0 to 7 are channel ports and offsets 8 to 15 are control ports: command, request, single mask, mode, byte-select clear, master reset, clear all masks and write all masks. The parameter `WSHIFT` selects byte-wide (0) or word-wide (1) operation. It shifts the host address before decoding, and it scales the address and length that are loaded and read back.

The byte-select machine has two states. `PTR_LO` selects the low byte and is the reset state. `PTR_HI` selects the high byte. The transition *toggle* moves it to the other state on every channel-port read or write. The transition *clear* forces `PTR_LO` on a write to the byte-select clear offset or the master reset offset, and *clear* takes priority over *toggle*.

Top module: `dmac_regfile`

## Requirements
- R1: After reset, mask_o is 4'hF, cmd_o is 0, status_o is 0, chan_init_o is 0, every mode byte is 0 and the byte select is in PTR_LO.
- R2: The decoded offset is host_addr shifted right by WSHIFT. The bits below WSHIFT are ignored. For offsets 0 to 7, bits [2:1] give the channel and bit 0 selects the address port (0) or the length port (1).
- R3: The byte select is shared by all channels. It toggles on every channel-port read and every channel-port write, and selects the low byte in PTR_LO and the high byte in PTR_HI. A write to offset 0xC returns it to PTR_LO.
- R4: A channel-port write in PTR_LO stores the data in bits [7:0] of the chosen base register, and a write in PTR_HI stores it in bits [15:8]. A write in PTR_HI also sets the current address to the base address shifted left by WSHIFT and clears the transferred count. In the next cycle it raises chan_init_o[channel] for exactly one cycle.
- R5: A read of the address port returns a byte of (current address + transferred count), or of (current address − transferred count) when bit 5 of the channel's mode byte is 1. The value is shifted right by WSHIFT before the byte is chosen.
- R6: A read of the length port returns a byte of ((base length << WSHIFT) − transferred count) >> WSHIFT.
- R7: A write to offset 0x8 updates cmd_o only when the data is 0 or has no bit set other than bit 2. Any other value leaves cmd_o unchanged.
- R8: A write to offset 0xB stores the whole data byte as the mode byte of channel data[1:0]. Mode byte i appears on mode_o[8*i+7:8*i].
- R9: A write to offset 0xA sets mask bit data[1:0] when data[2] is 1 and clears it otherwise. A write to 0xE clears all mask bits, and a write to 0xF loads data[3:0]. A read of 0xF returns {4'h0, mask}.
- R10: A write to offset 0xD sets the mask to 4'hF, clears the command and the status, and returns the byte select to PTR_LO.
- R11: A read of offset 0x8 returns the status byte and then clears status[3:0]. A tc_set bit that arrives in the same cycle survives the clear. Reads of control offsets 0x9 to 0xE return 0.
- R12: A write to offset 0x9 sets request bit status[4+data[1:0]] when data[2] is 1, clears it otherwise, and clears status[data[1:0]]. The inputs req_set and req_clr act after any host write in the same cycle, and req_clr wins over req_set.
- R13: eng_wr[i] loads channel i's current address from eng_addr and its transferred count from eng_cnt. A high-byte host write to the same channel in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4+WSHIFT | Host port address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe; ignored when host_wr is high |
| host_rdata | output | 8 | Read data, valid in the same cycle as host_rd, otherwise 0 |
| eng_wr | input | 4 | Per-channel position write-back strobes from the transfer engine |
| eng_addr | input | 16+WSHIFT | Current address written back by the engine |
| eng_cnt | input | 16+WSHIFT | Transferred count written back by the engine |
| tc_set | input | 4 | Sets terminal-count status bits [3:0] |
| req_set | input | 4 | Sets request status bits [7:4] |
| req_clr | input | 4 | Clears request status bits [7:4] |
| chan_init_o | output | 4 | One-cycle pulse after a channel is reinitialised |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Per-channel mask bits |
| status_o | output | 8 | Request bits [7:4] and terminal-count bits [3:0] |
| mode_o | output | 32 | Four mode bytes, channel 0 in the low byte |

## Verification
The bench builds the block with WSHIFT = 1. This is the word-wide variant, where the address shift and the value scaling are not the identity. As a result, a design that drops a shift on the load side or on the readback side returns a wrong byte, and the ignored low address bit can be tested. In that build the current address is 17 bits wide, so a base address of 0x8000 loads a current address of 0x10000, which brings the top bit of the widened register within reach. The count port readback checks the length scaling against the transferred count.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int NCH      = 4;
    localparam int BASE_W   = 16;
    localparam int MODE_W   = 8;
    localparam int DECR_BIT = 5;
    localparam logic [7:0] CMD_OK_BITS = 8'h04;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_t;

    typedef enum logic [3:0] {
        OFF_CMD     = 4'h8,
        OFF_REQ     = 4'h9,
        OFF_SMASK   = 4'hA,
        OFF_MODE    = 4'hB,
        OFF_CLRPTR  = 4'hC,
        OFF_MRESET  = 4'hD,
        OFF_CLRMASK = 4'hE,
        OFF_WRMASK  = 4'hF
    } ctl_off_t;

endpackage

// File: rtl/dmac_byteptr.sv
module dmac_byteptr
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic clear_i,
    output logic hi_o
);

    ptr_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    // transitions: clear has priority over toggle (R3)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: begin
                if (clear_i)     state_d = PTR_LO;
                else if (step_i) state_d = PTR_HI;
            end
            PTR_HI: begin
                if (clear_i)     state_d = PTR_LO;
                else if (step_i) state_d = PTR_LO;
            end
            default: state_d = PTR_LO;
        endcase
    end

    // outputs
    always_comb begin
        hi_o = 1'b0;
        unique case (state_q)
            PTR_LO:  hi_o = 1'b0;
            PTR_HI:  hi_o = 1'b1;
            default: hi_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter  int WSHIFT = 0,
    localparam int CW     = BASE_W + WSHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              cnt_sel_i,
    input  logic              hi_i,
    input  logic [7:0]        wdata_i,
    input  logic              eng_wr_i,
    input  logic [CW-1:0]     eng_addr_i,
    input  logic [CW-1:0]     eng_cnt_i,
    input  logic              decr_i,
    output logic [BASE_W-1:0] addr_rb_o,
    output logic [BASE_W-1:0] cnt_rb_o,
    output logic              init_o
);

    logic [BASE_W-1:0] base_addr_q, base_addr_d;
    logic [BASE_W-1:0] base_cnt_q,  base_cnt_d;
    logic [CW-1:0]     cur_addr_q;
    logic [CW-1:0]     xfer_q;
    logic              load;
    logic [CW-1:0]     pos_addr;
    logic [CW-1:0]     cnt_left;

    // byte-wise base register update (R4)
    always_comb begin
        base_addr_d = base_addr_q;
        base_cnt_d  = base_cnt_q;
        if (wr_i) begin
            if (cnt_sel_i) begin
                if (hi_i) base_cnt_d = {wdata_i, base_cnt_q[7:0]};
                else      base_cnt_d = {base_cnt_q[BASE_W-1:8], wdata_i};
            end else begin
                if (hi_i) base_addr_d = {wdata_i, base_addr_q[7:0]};
                else      base_addr_d = {base_addr_q[BASE_W-1:8], wdata_i};
            end
        end
    end

    assign load = wr_i & hi_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
            cur_addr_q  <= '0;
            xfer_q      <= '0;
            init_o      <= 1'b0;
        end else begin
            base_addr_q <= base_addr_d;
            base_cnt_q  <= base_cnt_d;
            init_o      <= load;
            if (load) begin                 // host reinit wins (R13)
                cur_addr_q <= CW'(base_addr_d) << WSHIFT;
                xfer_q     <= '0;
            end else if (eng_wr_i) begin
                cur_addr_q <= eng_addr_i;
                xfer_q     <= eng_cnt_i;
            end
        end
    end

    // live readback values (R5, R6)
    always_comb begin
        pos_addr  = decr_i ? (cur_addr_q - xfer_q) : (cur_addr_q + xfer_q);
        cnt_left  = (CW'(base_cnt_q) << WSHIFT) - xfer_q;
        addr_rb_o = BASE_W'(pos_addr >> WSHIFT);
        cnt_rb_o  = BASE_W'(cnt_left >> WSHIFT);
    end

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [3:0]            off_i,
    input  logic [7:0]            wdata_i,
    input  logic [NCH-1:0]        tc_set_i,
    input  logic [NCH-1:0]        req_set_i,
    input  logic [NCH-1:0]        req_clr_i,
    output logic [7:0]            cmd_o,
    output logic [NCH-1:0]        mask_o,
    output logic [2*NCH-1:0]      status_o,
    output logic [NCH*MODE_W-1:0] mode_o,
    output logic [7:0]            rdata_o
);

    logic [7:0]                 cmd_d;
    logic [NCH-1:0]             mask_d;
    logic [2*NCH-1:0]           status_d;
    logic [NCH-1:0][MODE_W-1:0] mode_q, mode_d;
    logic [1:0]                 sel_ch;

    assign sel_ch = wdata_i[1:0];

    always_comb begin
        cmd_d    = cmd_o;
        mask_d   = mask_o;
        status_d = status_o;
        mode_d   = mode_q;
        if (wr_i) begin
            case (off_i)
                OFF_CMD: begin      // R7
                    if ((wdata_i == 8'h00) || ((wdata_i & ~CMD_OK_BITS) == 8'h00))
                        cmd_d = wdata_i;
                end
                OFF_REQ: begin      // R12
                    status_d[NCH + 32'(sel_ch)] = wdata_i[2];
                    status_d[sel_ch]            = 1'b0;
                end
                OFF_SMASK:   mask_d[sel_ch] = wdata_i[2];       // R9
                OFF_MODE:    mode_d[sel_ch] = wdata_i;          // R8
                OFF_MRESET: begin   // R10
                    cmd_d    = '0;
                    mask_d   = '1;
                    status_d = '0;
                end
                OFF_CLRMASK: mask_d = '0;
                OFF_WRMASK:  mask_d = wdata_i[NCH-1:0];
                default: ;
            endcase
        end
        if (rd_i && (off_i == OFF_CMD))                         // R11
            status_d[NCH-1:0] = '0;
        status_d[2*NCH-1:NCH] = (status_d[2*NCH-1:NCH] | req_set_i) & ~req_clr_i;
        status_d[NCH-1:0]     = status_d[NCH-1:0] | tc_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o    <= '0;
            mask_o   <= '1;
            status_o <= '0;
            mode_q   <= '0;
        end else begin
            cmd_o    <= cmd_d;
            mask_o   <= mask_d;
            status_o <= status_d;
            mode_q   <= mode_d;
        end
    end

    assign mode_o = mode_q;

    always_comb begin
        case (off_i)
            OFF_CMD:    rdata_o = status_o;
            OFF_WRMASK: rdata_o = {{(8-NCH){1'b0}}, mask_o};
            default:    rdata_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter  int WSHIFT = 0,
    localparam int ADDR_W = 4 + WSHIFT,
    localparam int CW     = BASE_W + WSHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [7:0]            host_wdata,
    input  logic                  host_wr,
    input  logic                  host_rd,
    output logic [7:0]            host_rdata,
    input  logic [NCH-1:0]        eng_wr,
    input  logic [CW-1:0]         eng_addr,
    input  logic [CW-1:0]         eng_cnt,
    input  logic [NCH-1:0]        tc_set,
    input  logic [NCH-1:0]        req_set,
    input  logic [NCH-1:0]        req_clr,
    output logic [NCH-1:0]        chan_init_o,
    output logic [7:0]            cmd_o,
    output logic [NCH-1:0]        mask_o,
    output logic [2*NCH-1:0]      status_o,
    output logic [NCH*MODE_W-1:0] mode_o
);

    logic [3:0]        off;
    logic              is_chan;
    logic [1:0]        ch;
    logic              cnt_sel;
    logic              wr_act, rd_act;
    logic              ptr_step, ptr_clr, ptr_hi;
    logic [7:0]        ctl_rdata;
    logic [BASE_W-1:0] addr_rb [NCH];
    logic [BASE_W-1:0] cnt_rb  [NCH];
    logic [BASE_W-1:0] chan_val;
    logic [7:0]        chan_byte;

    // port decode (R2)
    assign off     = 4'(host_addr >> WSHIFT);
    assign is_chan = ~off[3];
    assign ch      = off[2:1];
    assign cnt_sel = off[0];
    assign wr_act  = host_wr;
    assign rd_act  = host_rd & ~host_wr;

    assign ptr_step = (wr_act | rd_act) & is_chan;
    assign ptr_clr  = wr_act & ~is_chan & ((off == OFF_CLRPTR) || (off == OFF_MRESET));

    dmac_byteptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (ptr_step),
        .clear_i (ptr_clr),
        .hi_o    (ptr_hi)
    );

    dmac_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_act & ~is_chan),
        .rd_i      (rd_act & ~is_chan),
        .off_i     (off),
        .wdata_i   (host_wdata),
        .tc_set_i  (tc_set),
        .req_set_i (req_set),
        .req_clr_i (req_clr),
        .cmd_o     (cmd_o),
        .mask_o    (mask_o),
        .status_o  (status_o),
        .mode_o    (mode_o),
        .rdata_o   (ctl_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dmac_chan #(.WSHIFT(WSHIFT)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (wr_act & is_chan & (ch == 2'(i))),
            .cnt_sel_i  (cnt_sel),
            .hi_i       (ptr_hi),
            .wdata_i    (host_wdata),
            .eng_wr_i   (eng_wr[i]),
            .eng_addr_i (eng_addr),
            .eng_cnt_i  (eng_cnt),
            .decr_i     (mode_o[i*MODE_W + DECR_BIT]),
            .addr_rb_o  (addr_rb[i]),
            .cnt_rb_o   (cnt_rb[i]),
            .init_o     (chan_init_o[i])
        );
    end

    always_comb begin
        chan_val   = cnt_sel ? cnt_rb[ch] : addr_rb[ch];
        chan_byte  = ptr_hi ? chan_val[15:8] : chan_val[7:0];
        host_rdata = !rd_act ? 8'h00 : (is_chan ? chan_byte : ctl_rdata);
    end

endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk
    import dmac_pkg::*;
#(
    parameter  int WSHIFT = 0,
    localparam int ADDR_W = 4 + WSHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_rdata,
    input logic [NCH-1:0]    tc_set,
    input logic [NCH-1:0]    chan_init_o,
    input logic [7:0]        cmd_o,
    input logic [NCH-1:0]    mask_o,
    input logic [2*NCH-1:0]  status_o,
    input logic              ptr_hi
);

    logic [3:0] c_off;
    logic       c_rd;
    logic       c_chan;
    assign c_off  = 4'(host_addr >> WSHIFT);
    assign c_rd   = host_rd & ~host_wr;
    assign c_chan = ~c_off[3];

    p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && c_chan) |=> (ptr_hi != $past(ptr_hi)));

    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && c_off == 4'hC) |=> !ptr_hi);

    p_init_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_init_o));

    p_init_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && c_chan && ptr_hi) |=> ($countones(chan_init_o) == 1));

    p_cmd_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && c_off == 4'h8 && host_wdata != 8'h00 && (host_wdata & 8'hFB) != 8'h00)
        |=> $stable(cmd_o));

    p_mreset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && c_off == 4'hD) |=> (mask_o == 4'hF && cmd_o == 8'h00 && !ptr_hi));

    p_tc_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && c_off == 4'h8 && tc_set == '0) |=> (status_o[NCH-1:0] == '0));

    p_ctl_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && c_off[3] && c_off != 4'h8 && c_off != 4'hF) |-> (host_rdata == 8'h00));

endmodule

bind dmac_regfile dmac_regfile_chk #(.WSHIFT(WSHIFT)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .tc_set      (tc_set),
    .chan_init_o (chan_init_o),
    .cmd_o       (cmd_o),
    .mask_o      (mask_o),
    .status_o    (status_o),
    .ptr_hi      (ptr_hi)
);

// File: tb/dmac_regfile_tb_top.sv
module dmac_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WSH        = 1;
    localparam int AW         = 4 + WSH;
    localparam int CW         = 16 + WSH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [7:0]    host_rdata;
    logic [3:0]    eng_wr = '0;
    logic [CW-1:0] eng_addr = '0;
    logic [CW-1:0] eng_cnt = '0;
    logic [3:0]    tc_set = '0;
    logic [3:0]    req_set = '0;
    logic [3:0]    req_clr = '0;
    logic [3:0]    chan_init_o;
    logic [7:0]    cmd_o;
    logic [3:0]    mask_o;
    logic [7:0]    status_o;
    logic [31:0]   mode_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_regfile #(.WSHIFT(WSH)) dut_i (.*);

    typedef struct packed {
        logic       rd;
        logic [3:0] off;
        logic [7:0] data;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 4'h0, 8'h34, 8'h00},  // R4 ch0 address low byte
        '{1'b0, 4'h0, 8'h12, 8'h00},  // R4 high byte, reinit
        '{1'b0, 4'h1, 8'h10, 8'h00},  // R4 ch0 length low byte
        '{1'b0, 4'h1, 8'h00, 8'h00},  // R4 high byte
        '{1'b1, 4'h0, 8'h00, 8'h34},  // R5 address low after scaling
        '{1'b1, 4'h0, 8'h00, 8'h12},  // R3 second read takes high byte
        '{1'b1, 4'h1, 8'h00, 8'h10},  // R6 length low
        '{1'b1, 4'h1, 8'h00, 8'h00},  // R6 length high
        '{1'b0, 4'hB, 8'h20, 8'h00},  // R8 ch0 decrement mode
        '{1'b1, 4'h0, 8'h00, 8'h34},  // R5 zero count, same value
        '{1'b0, 4'hC, 8'h00, 8'h00},  // R3 clear byte select
        '{1'b1, 4'hF, 8'h00, 8'h0F},  // R1 reset mask readback
        '{1'b0, 4'hA, 8'h00, 8'h00},  // R9 clear mask ch0
        '{1'b1, 4'hF, 8'h00, 8'h0E},  // R9
        '{1'b0, 4'hF, 8'hA5, 8'h00},  // R9 write all masks
        '{1'b1, 4'hF, 8'h00, 8'h05},  // R9
        '{1'b0, 4'hE, 8'h00, 8'h00},  // R9 clear all masks
        '{1'b1, 4'hF, 8'h00, 8'h00},  // R9
        '{1'b1, 4'h9, 8'h00, 8'h00},  // R11 other control read
        '{1'b0, 4'h9, 8'h06, 8'h00},  // R12 request ch2 set
        '{1'b1, 4'h8, 8'h00, 8'h40},  // R11 status read
        '{1'b0, 4'h8, 8'h04, 8'h00},  // R7 accepted command
        '{1'b0, 4'h8, 8'h01, 8'h00},  // R7 rejected command
        '{1'b1, 4'hE, 8'h00, 8'h00}   // R11 other control read
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] a_of(input logic [3:0] off);
        return AW'(off) << WSH;
    endfunction

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", 32'(mask_o), 32'h0F);
        chk("R1 cmd", 32'(cmd_o), 32'h00);
        chk("R1 status", 32'(status_o), 32'h00);
        chk("R1 init", 32'(chan_init_o), 32'h0);
        chk("R1 mode", mode_o, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].rd) begin
                bus_read(a_of(VEC[i].off), v);
                chk($sformatf("vector %0d", i), 32'(v), 32'(VEC[i].exp));
            end else begin
                bus_write(a_of(VEC[i].off), VEC[i].data);
            end
        end

        chk("R7 command kept", 32'(cmd_o), 32'h04);
        chk("R8 mode ch0", 32'(mode_o[7:0]), 32'h20);

        // R13 engine write-back, decrement readback
        eng_wr = 4'b0001; eng_addr = CW'(17'h02468); eng_cnt = CW'(17'h6);
        tick();
        eng_wr = '0;
        bus_read(a_of(4'h0), v); chk("R5 decr low", 32'(v), 32'h31);
        bus_read(a_of(4'h0), v); chk("R5 decr high", 32'(v), 32'h12);
        bus_read(a_of(4'h1), v); chk("R6 left low", 32'(v), 32'h0D);
        bus_read(a_of(4'h1), v); chk("R6 left high", 32'(v), 32'h00);
        bus_write(a_of(4'hB), 8'h00);
        bus_read(a_of(4'h0), v); chk("R5 incr low", 32'(v), 32'h37);
        bus_read(a_of(4'h0), v); chk("R5 incr high", 32'(v), 32'h12);

        // R2 low address bit ignored
        bus_write(a_of(4'hA) | AW'(1), 8'h05);
        bus_read(a_of(4'hF), v); chk("R2 low bit ignored", 32'(v), 32'h02);

        // R4 reinit pulse on ch1
        bus_write(a_of(4'h2), 8'h00);
        chk("R4 no pulse on low", 32'(chan_init_o), 32'h0);
        bus_write(a_of(4'h2), 8'h80);
        chk("R4 pulse", 32'(chan_init_o), 32'h2);
        tick();
        chk("R4 pulse ends", 32'(chan_init_o), 32'h0);
        bus_read(a_of(4'h2), v); chk("R4 addr low", 32'(v), 32'h00);
        bus_read(a_of(4'h2), v); chk("R4 addr high", 32'(v), 32'h80);

        // R13 host reinit wins over engine in the same cycle
        bus_write(a_of(4'h3), 8'h07);
        eng_wr = 4'b0010; eng_addr = '0; eng_cnt = CW'(17'h5);
        bus_write(a_of(4'h3), 8'h00);
        eng_wr = '0;
        bus_read(a_of(4'h3), v); chk("R13 reinit priority", 32'(v), 32'h07);
        bus_read(a_of(4'h3), v);

        // R11 terminal count and status read clear
        @(negedge clk); tc_set = 4'b0010;
        tick(); tc_set = '0;
        chk("R11 tc set", 32'(status_o), 32'h42);
        bus_read(a_of(4'h8), v); chk("R11 status read", 32'(v), 32'h42);
        chk("R11 tc cleared", 32'(status_o), 32'h40);
        @(negedge clk);
        tc_set = 4'b1000; host_addr = a_of(4'h8); host_rd = 1'b1;
        #1 v = host_rdata;
        tick();
        host_rd = 1'b0; tc_set = '0;
        chk("R11 same-cycle read", 32'(v), 32'h40);
        chk("R11 same-cycle set survives", 32'(status_o), 32'h48);

        // R12 request writes and external request inputs
        bus_write(a_of(4'h9), 8'h03);
        chk("R12 request clear", 32'(status_o), 32'h40);
        @(negedge clk); req_clr = 4'b0100;
        tick(); req_clr = '0;
        chk("R12 external clear", 32'(status_o), 32'h00);
        @(negedge clk); req_set = 4'b0010; req_clr = 4'b0010;
        tick(); req_set = '0; req_clr = '0;
        chk("R12 clear wins", 32'(status_o), 32'h00);
        @(negedge clk); req_set = 4'b0001;
        tick(); req_set = '0;
        chk("R12 external set", 32'(status_o), 32'h10);

        // R10 master reset
        bus_read(a_of(4'h0), v);
        bus_write(a_of(4'hD), 8'h00);
        chk("R10 mask", 32'(mask_o), 32'h0F);
        chk("R10 cmd", 32'(cmd_o), 32'h00);
        chk("R10 status", 32'(status_o), 32'h00);
        bus_read(a_of(4'h2), v); chk("R10 byte select low", 32'(v), 32'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule